// File: doc/BRIEF.md
# Candidate Join Cell

This cell is one stage of a linear chain used to build the next generation of frequent itemsets. It holds a single ordered candidate of `CAND_LEN` items, written in serially over a load port. The candidates of the current generation are then streamed past it, one item per valid cycle. For each passing candidate, the cell checks whether all items before the final one equal its own. It also checks whether its own final item is strictly larger than the passing candidate's final item. When both hold, the two candidates can be merged into an ordered candidate one item longer.

On such a join, the cell does not report its identity or a whole new candidate. It raises an injection request that carries only its own final item. The stall logic around the cell places that word directly behind the candidate that triggered it. The controller rebuilds the longer candidate from the prefix it already knows plus this suffix word. Injected words travel with a tag bit, and every cell skips tagged words when comparing. A suffix inserted by an upstream cell therefore never disturbs the position count of a downstream cell.

Top module: `joinCell`

## Requirements
- R1: After reset, `injReq` is low, and it stays low until a join occurs.
- R2: A join occurs when the passing candidate equals the stored candidate at every position 0 to `CAND_LEN`-2 and the stored item at position `CAND_LEN`-1 is strictly greater (unsigned) than the passing item at that position. `injReq` is then high in the cycle after the one in which the final item was presented.
- R3: An inequality at any single prefix position (0 to `CAND_LEN`-2) blocks the join for that candidate.
- R4: A stored final item that is equal to or smaller than the passing final item produces no request.
- R5: While `injReq` is high, `injData` equals the stored item at position `CAND_LEN`-1.
- R6: Once raised, `injReq` stays high until `injAck` is sampled high at a clock edge. It falls at that edge unless a new join is detected at the same edge.
- R7: Stream words with `strmSuffix`=1 are ignored by the compare and do not advance the position, even when they fall in the middle of a candidate.
- R8: Loading: a `loadValid` word with `loadFirst`=1 is written to position 0. Each following `loadValid` word is written to the next position, and words after position `CAND_LEN`-1 are ignored until the next `loadFirst`.
- R9: `strmFirst`=1 marks position 0 of a new candidate and clears any prefix mismatch of the previous one. Untagged words arriving after position `CAND_LEN`-1 without `strmFirst` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadValid | input | 1 | Load word valid |
| loadFirst | input | 1 | Load word is position 0 |
| loadData | input | ITEM_W | Item to store |
| strmValid | input | 1 | Stream word valid |
| strmFirst | input | 1 | Stream word is position 0 of a candidate |
| strmSuffix | input | 1 | Stream word is an injected suffix (skipped) |
| strmData | input | ITEM_W | Stream item |
| injAck | input | 1 | Stall logic has accepted the injection |
| injReq | output | 1 | Injection request (join found) |
| injData | output | ITEM_W | Suffix item to inject |

## Verification
The join result registers once, so a request is due exactly one cycle after the final item of a candidate is presented. It is then released one cycle after the acknowledge. The driver stamps each expected suffix word with that due cycle. The monitor compares both the data and the cycle in which the request appears, and it then checks that the request stays up through a chosen acknowledge delay and drops one cycle after the acknowledge. For candidates that must not join, the driver samples `injReq` in the same due cycle. Any request that the scoreboard did not expect is reported as a failure.

// File: rtl/joinCellPkg.sv
package joinCellPkg;
  parameter int IDX_W = 8;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] cmpIdx;
    logic             clrMis;
    logic             chkPrefix;
    logic             chkLast;
  } joinStrobe_t;
endpackage

// File: rtl/joinCtrl.sv
module joinCtrl import joinCellPkg::*; #(
  parameter int CAND_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loadValid,
  input  logic        loadFirst,
  input  logic        strmValid,
  input  logic        strmFirst,
  input  logic        strmSuffix,
  input  logic        joinHit,
  input  logic        injAck,
  output joinStrobe_t strb,
  output logic        injReq
);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(CAND_LEN - 1);
  localparam logic [IDX_W-1:0] END_POS  = IDX_W'(CAND_LEN);

  logic [IDX_W-1:0] loadPtr, cmpPtr, loadPos, cmpPos;
  logic             itemValid, loadInRange, cmpInRange;

  always_comb begin
    loadPos     = loadFirst ? '0 : loadPtr;
    cmpPos      = strmFirst ? '0 : cmpPtr;
    itemValid   = strmValid & ~strmSuffix;
    loadInRange = loadValid && (loadPos < END_POS);
    cmpInRange  = itemValid && (cmpPos < END_POS);

    strb.wrEn      = loadInRange;
    strb.wrIdx     = loadPos;
    strb.cmpIdx    = cmpPos;
    strb.clrMis    = itemValid & strmFirst;
    strb.chkPrefix = itemValid && (cmpPos < LAST_POS);
    strb.chkLast   = itemValid && (cmpPos == LAST_POS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadPtr <= END_POS;
      cmpPtr  <= END_POS;
      injReq  <= 1'b0;
    end else begin
      if (loadInRange) loadPtr <= loadPos + 1'b1;
      if (cmpInRange)  cmpPtr  <= cmpPos + 1'b1;
      injReq <= joinHit | (injReq & ~injAck);
    end
  end
endmodule

// File: rtl/joinDatapath.sv
module joinDatapath import joinCellPkg::*; #(
  parameter int ITEM_W   = 16,
  parameter int CAND_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  joinStrobe_t       strb,
  input  logic [ITEM_W-1:0] loadData,
  input  logic [ITEM_W-1:0] strmData,
  output logic              joinHit,
  output logic [ITEM_W-1:0] lastItem
);
  logic [CAND_LEN-1:0][ITEM_W-1:0] candMem;
  logic [ITEM_W-1:0] cmpItem;
  logic              itemEq, itemGt, misFlag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      candMem <= '0;
    end else begin
      for (int i = 0; i < CAND_LEN; i++) begin
        if (strb.wrEn && strb.wrIdx == IDX_W'(i)) candMem[i] <= loadData;
      end
    end
  end

  always_comb begin
    cmpItem = '0;
    for (int i = 0; i < CAND_LEN; i++) begin
      if (strb.cmpIdx == IDX_W'(i)) cmpItem = candMem[i];
    end
    itemEq = (cmpItem == strmData);
    itemGt = (cmpItem > strmData);
  end

  // Sticky prefix mismatch for the candidate currently passing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misFlag <= 1'b0;
    end else if (strb.clrMis) begin
      misFlag <= strb.chkPrefix & ~itemEq;
    end else if (strb.chkPrefix & ~itemEq) begin
      misFlag <= 1'b1;
    end
  end

  assign joinHit  = strb.chkLast & ~misFlag & itemGt;
  assign lastItem = candMem[CAND_LEN-1];
endmodule

// File: rtl/joinCell.sv
module joinCell import joinCellPkg::*; #(
  parameter int ITEM_W   = 16,
  parameter int CAND_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadValid,
  input  logic              loadFirst,
  input  logic [ITEM_W-1:0] loadData,
  input  logic              strmValid,
  input  logic              strmFirst,
  input  logic              strmSuffix,
  input  logic [ITEM_W-1:0] strmData,
  input  logic              injAck,
  output logic              injReq,
  output logic [ITEM_W-1:0] injData
);
  joinStrobe_t strb;
  logic        joinHit;

  joinCtrl #(.CAND_LEN(CAND_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .loadValid(loadValid), .loadFirst(loadFirst),
    .strmValid(strmValid), .strmFirst(strmFirst), .strmSuffix(strmSuffix),
    .joinHit(joinHit), .injAck(injAck),
    .strb(strb), .injReq(injReq)
  );

  joinDatapath #(.ITEM_W(ITEM_W), .CAND_LEN(CAND_LEN)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .loadData(loadData), .strmData(strmData),
    .joinHit(joinHit), .lastItem(injData)
  );
endmodule

// File: rtl/joinCellChecker.sv
module joinCellChecker #(
  parameter int ITEM_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loadValid,
  input logic              strmValid,
  input logic              strmSuffix,
  input logic              injAck,
  input logic              injReq,
  input logic [ITEM_W-1:0] injData
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !injReq);

  p_rise_after_item_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(injReq) |-> $past(strmValid && !strmSuffix));

  p_data_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    injReq && !injAck && !loadValid |=> $stable(injData));

  p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    injReq && !injAck |=> injReq);

  p_suffix_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !injReq && (!strmValid || strmSuffix) |=> !injReq);
endmodule

bind joinCell joinCellChecker #(.ITEM_W(ITEM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .loadValid(loadValid), .strmValid(strmValid),
  .strmSuffix(strmSuffix), .injAck(injAck), .injReq(injReq), .injData(injData)
);

// File: tb/joinCell_bench.sv
`timescale 1ns/1ps
module joinCell_bench;
  localparam int W = 16;
  localparam int M = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loadValid = 1'b0, loadFirst = 1'b0;
  logic [W-1:0] loadData = '0;
  logic strmValid = 1'b0, strmFirst = 1'b0, strmSuffix = 1'b0;
  logic [W-1:0] strmData = '0;
  logic injAck;
  logic injReq;
  logic [W-1:0] injData;

  always #2.5 clk = ~clk;

  joinCell #(.ITEM_W(W), .CAND_LEN(M)) u_joinCell (
    .clk(clk), .rst_n(rst_n), .loadValid(loadValid), .loadFirst(loadFirst),
    .loadData(loadData), .strmValid(strmValid), .strmFirst(strmFirst),
    .strmSuffix(strmSuffix), .strmData(strmData), .injAck(injAck),
    .injReq(injReq), .injData(injData)
  );

  typedef struct { logic [W-1:0] data; int due; } expItem_t;
  expItem_t expQ[$];
  logic [W-1:0] model [M];
  int cyc = 0;
  int errCnt = 0;
  int chkCnt = 0;
  int ackDelay = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic loadCand(input logic [6*W-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      loadValid = 1'b1;
      loadFirst = (i == 0);
      loadData  = v[i*W +: W];
      if (i < M) model[i] = v[i*W +: W];
      @(negedge clk);
    end
    loadValid = 1'b0;
    loadFirst = 1'b0;
  endtask

  // Drive one candidate; sufPos >= 0 inserts a tagged word before that position
  task automatic sendCand(input logic [M*W-1:0] v, input int sufPos,
                          input logic [W-1:0] sufData, input int extra,
                          input int gap, input string req);
    bit expJoin = 1'b1;
    for (int p = 0; p < M - 1; p++)
      if (v[p*W +: W] != model[p]) expJoin = 1'b0;
    if (!(model[M-1] > v[(M-1)*W +: W])) expJoin = 1'b0;
    for (int p = 0; p < M; p++) begin
      if (p == sufPos) begin
        strmValid = 1'b1; strmSuffix = 1'b1; strmFirst = 1'b0; strmData = sufData;
        @(negedge clk);
      end
      strmValid = 1'b1; strmSuffix = 1'b0; strmFirst = (p == 0);
      strmData = v[p*W +: W];
      if (p == M - 1 && expJoin) expQ.push_back('{model[M-1], cyc + 1});
      @(negedge clk);
    end
    for (int e = 0; e < extra; e++) begin
      strmValid = 1'b1; strmSuffix = 1'b0; strmFirst = 1'b0; strmData = 16'd1;
      @(negedge clk);
    end
    if (!expJoin) check(injReq == 1'b0, req, "request without join", injReq, 0);
    strmValid = 1'b0; strmFirst = 1'b0; strmSuffix = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    expItem_t e;
    injAck = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && injReq) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected request", 1, 0);
        end else begin
          e = expQ.pop_front();
          check(injData == e.data, "R5", "suffix data", injData, e.data);
          check(cyc == e.due, "R2", "request cycle", cyc, e.due);
        end
        for (int d = 0; d < ackDelay; d++) begin
          @(negedge clk);
          check(injReq == 1'b1, "R6", "held before ack", injReq, 1);
        end
        injAck = 1'b1;
        @(negedge clk);
        injAck = 1'b0;
        check(injReq == 1'b0, "R6", "release after ack", injReq, 0);
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      errCnt++; chkCnt++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(injReq == 1'b0, "R1", "reset request", injReq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(injReq == 1'b0, "R1", "idle after reset", injReq, 0);

    // R8: six load words, the last two are beyond the candidate and ignored
    loadCand({16'd1, 16'd99, 16'd40, 16'd30, 16'd20, 16'd10}, 6);

    // R2, R5: join with strictly smaller passing last item
    sendCand({16'd35, 16'd30, 16'd20, 16'd10}, -1, '0, 0, 6, "R2");
    // R4: equal last item, then larger last item
    sendCand({16'd40, 16'd30, 16'd20, 16'd10}, -1, '0, 0, 2, "R4");
    sendCand({16'd50, 16'd30, 16'd20, 16'd10}, -1, '0, 0, 2, "R4");
    // R3: mismatch at position 0, then at position 2
    sendCand({16'd35, 16'd30, 16'd20, 16'd11}, -1, '0, 0, 2, "R3");
    sendCand({16'd35, 16'd31, 16'd20, 16'd10}, -1, '0, 0, 2, "R3");
    // R9: mismatching candidate followed back-to-back by a joining one
    sendCand({16'd35, 16'd30, 16'd99, 16'd10}, -1, '0, 0, 0, "R9");
    sendCand({16'd1,  16'd30, 16'd20, 16'd10}, -1, '0, 0, 6, "R9");
    // R7: tagged suffix words inside the candidate are skipped
    sendCand({16'd35, 16'd30, 16'd20, 16'd10}, 2, 16'd77, 0, 6, "R7");
    sendCand({16'd35, 16'd30, 16'd20, 16'd10}, 3, 16'd5, 0, 6, "R7");
    // R6: acknowledge delayed by three cycles
    ackDelay = 3;
    sendCand({16'd2, 16'd30, 16'd20, 16'd10}, -1, '0, 0, 10, "R6");
    ackDelay = 0;
    // R9: untagged word past the last position is ignored (no second request)
    sendCand({16'd35, 16'd30, 16'd20, 16'd10}, -1, '0, 1, 8, "R9");
    // R8: reload restarts at position 0
    loadCand({32'd0, 16'd8, 16'd7, 16'd6, 16'd5}, 4);
    sendCand({16'd2, 16'd7, 16'd6, 16'd5}, -1, '0, 0, 6, "R8");
    sendCand({16'd35, 16'd30, 16'd20, 16'd10}, -1, '0, 0, 4, "R8");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2", "missing requests", expQ.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule